// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block lets a host run one paged management-register transaction against a PHY attached to a selected switch port. The host programs a small register file: a command word with the page, the register number and a write flag, a data word whose upper half carries either the target port (reads) or the value to write (writes), and a wide port-select mask that names the target port of a write by a single set bit. Setting the execute bit in the command word launches the transaction. Execute reads back as 1 until the PHY side answers, and then drops.

The PHY side is a plain request/acknowledge port. While a transaction is open, the block holds the request high with stable port, page, register, direction and write data. A single-cycle acknowledge closes the transaction and returns read data and an error indication. Requests whose fields are out of range are refused at once, without touching the PHY side, and they raise the failure flag. The top page value is a special page: it is accepted, and it also shows a five-bit extension field in the command word.

Top module: `phyacc_top`

## Requirements
- R1: After reset every host register reads 0 and `phy_req` is 0.
- R2: The command word (address 0) holds the register number in bits [9:5], the page in bits [22:10] and the write flag in bit 3. Bit 0 is execute/busy, bit 1 is the failure flag, and all other bits read 0 apart from [27:23]. A command write made while idle stores these fields.
- R3: Bits [27:23] of the command word read 5'h1F when the stored page is 13'h1FFF, and 0 for any other page.
- R4: A command write made while idle with bit 0 set and valid fields sets bit 0 and `phy_req` from the next cycle on. The request then holds its port, page, register, direction and write data stable until it is acknowledged.
- R5: When `phy_ack` is sampled with `phy_req` high, both bit 0 and `phy_req` read 0 from the next cycle on.
- R6: For a read (bit 3 = 0), `phy_port` is the value in data word (address 1) bits [31:16]. On completion, `phy_rdata` lands in data bits [15:0] and bits [31:16] are kept.
- R7: For a write (bit 3 = 1), `phy_wdata` is data bits [31:16] and `phy_port` is the index of the single set bit in the port-select mask. Address 2 holds ports 0..31 and address 3 holds ports 32..63. Data bits [15:0] are left unchanged by a write.
- R8: A command is refused if any of these holds: the page is above 4095 and is not 13'h1FFF; a read names a port above 63; or a write has a port-select mask without exactly one set bit. A refused command raises no `phy_req`, leaves bit 0 at 0 and sets bit 1.
- R9: If `phy_err` is high together with the closing `phy_ack`, bit 1 reads 1 after completion. If it is low, bit 1 reads 0.
- R10: A command write made while busy, including one made in the cycle of the acknowledge, is ignored. The stored fields, the open request and the start of any new request are all unaffected.
- R11: Issuing a new command (a command write with bit 0 set while idle) clears bit 1, unless that command is refused.
- R12: A command write with bit 0 clear updates the fields only. It starts no transaction and leaves bit 1 as it was.
- R13: A host write to the data word in the same cycle as a read completion takes effect together with it. The upper half takes the host value and the lower half takes `phy_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address (0 command, 1 data, 2..3 port-select words) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr`, combinational |
| phy_req | output | 1 | Transaction request, held until acknowledged |
| phy_port | output | 6 | Target port |
| phy_page | output | 13 | Target page |
| phy_reg | output | 5 | Target register number |
| phy_wr | output | 1 | 1 = write, 0 = read |
| phy_wdata | output | 16 | Write data |
| phy_ack | input | 1 | Transaction complete, one cycle |
| phy_rdata | input | 16 | Read result, valid with `phy_ack` |
| phy_err | input | 1 | Failure response, valid with `phy_ack` |

## Verification
Two pairs of events can land in the same clock edge. A read completion and a host write can both update the data word, and an acknowledge can arrive together with a new execute request. The bench uses a hand-driven acknowledge to force each pair into one cycle. In the first case it requires the host value in the upper half and the PHY value in the lower half. In the second case it requires the command fields unchanged and no request raised afterward. Around these cases, sweeps cover all 64 ports in both directions, every register number and the page limits.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;
  localparam int PAGE_W  = 13;
  localparam int REG_W   = 5;
  localparam int HALF_W  = 16;
  localparam int EXT_W   = 5;
  localparam logic [PAGE_W-1:0] SPECIAL_PAGE = 13'h1FFF;
  localparam int PAGE_LIMIT = 4095;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [REG_W-1:0]  regn;
    logic              wr;
    logic [HALF_W-1:0] wdata;
  } phy_cmd_t;

  function automatic logic [EXT_W-1:0] ext_field(input logic [PAGE_W-1:0] page);
    return (page == SPECIAL_PAGE) ? 5'h1F : 5'h00;
  endfunction

  function automatic logic page_ok(input logic [PAGE_W-1:0] page);
    return (int'(page) <= PAGE_LIMIT) || (page == SPECIAL_PAGE);
  endfunction

  function automatic logic [31:0] pack_access(input logic [PAGE_W-1:0] page,
                                              input logic [REG_W-1:0] regn,
                                              input logic wr, input logic err,
                                              input logic busy);
    return {4'b0, ext_field(page), page, regn, 1'b0, wr, 1'b0, err, busy};
  endfunction
endpackage

// File: rtl/phyacc_check.sv
module phyacc_check
  import phyacc_pkg::*;
#(
  parameter int N_PORTS = 64,
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic               wr,
  input  logic [PAGE_W-1:0]  page,
  input  logic [HALF_W-1:0]  port_field,
  input  logic [N_PORTS-1:0] psel,
  output logic               ok,
  output logic [PORT_W-1:0]  port_sel
);
  logic [PORT_W-1:0] onehot_idx;
  logic              port_ok;

  always_comb begin
    onehot_idx = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (psel[i]) onehot_idx = PORT_W'(i);
    end
  end

  assign port_ok  = wr ? ($countones(psel) == 1) : (int'(port_field) < N_PORTS);
  assign ok       = port_ok && page_ok(page);
  assign port_sel = wr ? onehot_idx : port_field[PORT_W-1:0];
endmodule

// File: rtl/phyacc_seq.sv
module phyacc_seq
  import phyacc_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  phy_cmd_t          start_cmd,
  input  logic [PORT_W-1:0] start_port,
  input  logic              phy_ack,
  output logic              busy,
  output logic              done,
  output phy_cmd_t          cur_cmd,
  output logic [PORT_W-1:0] cur_port
);
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;
  seq_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_cmd  <= '0;
      cur_port <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_WAIT;
          cur_cmd  <= start_cmd;
          cur_port <= start_port;
        end
        ST_WAIT: if (phy_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WAIT);
  assign done = busy && phy_ack;
endmodule

// File: rtl/phyacc_top.sv
module phyacc_top
  import phyacc_pkg::*;
#(
  parameter int N_PORTS = 64,
  localparam int PORT_W     = $clog2(N_PORTS),
  localparam int PSEL_WORDS = (N_PORTS + 31) / 32,
  localparam int N_REGS     = 2 + PSEL_WORDS,
  localparam int ADDR_W     = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              phy_req,
  output logic [PORT_W-1:0] phy_port,
  output logic [PAGE_W-1:0] phy_page,
  output logic [REG_W-1:0]  phy_reg,
  output logic              phy_wr,
  output logic [HALF_W-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [HALF_W-1:0] phy_rdata,
  input  logic              phy_err
);
  logic [PAGE_W-1:0]        page_q;
  logic [REG_W-1:0]         reg_q;
  logic                     wr_q, err_q;
  logic [HALF_W-1:0]        data_hi_q, data_lo_q;
  logic [PSEL_WORDS*32-1:0] psel_q;

  // named events for the checker
  logic acc_wr, cmd_issue, cmd_launch, cmd_reject, xfer_done, busy;
  logic chk_ok;
  logic [PORT_W-1:0] chk_port;
  phy_cmd_t start_cmd, cur_cmd;

  assign acc_wr     = host_we && (host_addr == '0);
  assign cmd_issue  = acc_wr && host_wdata[0] && !busy;
  assign cmd_launch = cmd_issue && chk_ok;
  assign cmd_reject = cmd_issue && !chk_ok;

  phyacc_check #(.N_PORTS(N_PORTS)) u_check (
    .wr        (host_wdata[3]),
    .page      (host_wdata[22:10]),
    .port_field(data_hi_q),
    .psel      (psel_q[N_PORTS-1:0]),
    .ok        (chk_ok),
    .port_sel  (chk_port)
  );

  assign start_cmd = '{page: host_wdata[22:10], regn: host_wdata[9:5],
                       wr: host_wdata[3], wdata: data_hi_q};

  phyacc_seq #(.PORT_W(PORT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_launch),
    .start_cmd (start_cmd),
    .start_port(chk_port),
    .phy_ack   (phy_ack),
    .busy      (busy),
    .done      (xfer_done),
    .cur_cmd   (cur_cmd),
    .cur_port  (phy_port)
  );

  assign phy_req   = busy;
  assign phy_page  = cur_cmd.page;
  assign phy_reg   = cur_cmd.regn;
  assign phy_wr    = cur_cmd.wr;
  assign phy_wdata = cur_cmd.wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q    <= '0;
      reg_q     <= '0;
      wr_q      <= 1'b0;
      err_q     <= 1'b0;
      data_hi_q <= '0;
      data_lo_q <= '0;
    end else begin
      if (acc_wr && !busy) begin
        page_q <= host_wdata[22:10];
        reg_q  <= host_wdata[9:5];
        wr_q   <= host_wdata[3];
      end
      if (cmd_issue)      err_q <= !chk_ok;
      else if (xfer_done) err_q <= phy_err;
      if (host_we && host_addr == ADDR_W'(1)) data_hi_q <= host_wdata[31:16];
      if (xfer_done && !cur_cmd.wr)           data_lo_q <= phy_rdata;
    end
  end

  for (genvar k = 0; k < PSEL_WORDS; k++) begin : g_psel
    always_ff @(posedge clk) begin
      if (!rst_n) psel_q[k*32 +: 32] <= '0;
      else if (host_we && host_addr == ADDR_W'(2 + k)) psel_q[k*32 +: 32] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == '0)             host_rdata = pack_access(page_q, reg_q, wr_q, err_q, busy);
    else if (host_addr == ADDR_W'(1)) host_rdata = {data_hi_q, data_lo_q};
    for (int k = 0; k < PSEL_WORDS; k++) begin
      if (host_addr == ADDR_W'(2 + k)) host_rdata = psel_q[k*32 +: 32];
    end
  end
endmodule

// File: rtl/phyacc_checker.sv
module phyacc_checker
  import phyacc_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phy_req,
  input logic              phy_ack,
  input logic              phy_err,
  input logic [PORT_W-1:0] phy_port,
  input logic [PAGE_W-1:0] phy_page,
  input logic [REG_W-1:0]  phy_reg,
  input logic              phy_wr,
  input logic [HALF_W-1:0] phy_wdata,
  input logic              acc_wr,
  input logic              cmd_issue,
  input logic              cmd_reject,
  input logic              busy,
  input logic              err_q,
  input logic [PAGE_W-1:0] page_q,
  input logic [REG_W-1:0]  reg_q,
  input logic              wr_q
);
  assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue && !cmd_reject |=> phy_req);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> phy_req && $stable(phy_port) && $stable(phy_page)
      && $stable(phy_reg) && $stable(phy_wr) && $stable(phy_wdata));

  assert_done_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_ack |=> !phy_req && !busy);

  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> !phy_req && err_q);

  assert_phy_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_ack |=> err_q == $past(phy_err));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && busy |=> $stable(page_q) && $stable(reg_q) && $stable(wr_q));

  assert_ack_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_ack && acc_wr |=> !phy_req);
endmodule

bind phyacc_top phyacc_checker #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy_req(phy_req), .phy_ack(phy_ack), .phy_err(phy_err),
  .phy_port(phy_port), .phy_page(phy_page), .phy_reg(phy_reg), .phy_wr(phy_wr),
  .phy_wdata(phy_wdata), .acc_wr(acc_wr), .cmd_issue(cmd_issue), .cmd_reject(cmd_reject),
  .busy(busy), .err_q(err_q), .page_q(page_q), .reg_q(reg_q), .wr_q(wr_q)
);

// File: tb/tb_phyacc_top.sv
`timescale 1ns/1ps
module tb_phyacc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_req, phy_wr;
  logic [5:0]  phy_port;
  logic [12:0] phy_page;
  logic [4:0]  phy_reg;
  logic [15:0] phy_wdata, phy_rdata;
  logic        phy_ack, phy_err;
  logic        ack_auto = 1'b0, ack_man = 1'b0, err_cfg = 1'b0, auto_en = 1'b1;
  int          delay_cfg = 0, cnt = 0, acks = 0;
  logic [5:0]  cap_port;
  logic [12:0] cap_page;
  logic [4:0]  cap_reg;
  logic        cap_wr;
  logic [15:0] cap_wdata;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  phyacc_top dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_req(phy_req),
    .phy_port(phy_port), .phy_page(phy_page), .phy_reg(phy_reg), .phy_wr(phy_wr),
    .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata), .phy_err(phy_err)
  );

  function automatic logic [15:0] model_rd(input logic [5:0] p, input logic [4:0] r,
                                           input logic [12:0] pg);
    return {p, r, pg[4:0]} ^ 16'hA5C3;
  endfunction

  function automatic logic [31:0] cmd_word(input int pg, input int r, input bit wr, input bit ex);
    return (32'(pg) << 10) | (32'(r) << 5) | (32'(wr) << 3) | 32'(ex);
  endfunction

  function automatic logic [31:0] exp_acc(input int pg, input int r, input bit wr,
                                          input bit err, input bit bsy);
    logic [31:0] ext;
    ext = (pg == 8191) ? 32'h1F : 32'h0;
    return (ext << 23) | (32'(pg) << 10) | (32'(r) << 5) | (32'(wr) << 3)
         | (32'(err) << 1) | 32'(bsy);
  endfunction

  assign phy_ack   = ack_auto | ack_man;
  assign phy_rdata = model_rd(phy_port, phy_reg, phy_page);
  assign phy_err   = err_cfg;

  always @(negedge clk) begin
    if (ack_auto) ack_auto = 1'b0;
    else if (auto_en && phy_req) begin
      if (cnt >= delay_cfg) begin
        ack_auto = 1'b1; cnt = 0; acks++;
        cap_port = phy_port; cap_page = phy_page; cap_reg = phy_reg;
        cap_wr = phy_wr; cap_wdata = phy_wdata;
      end else cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      hread(2'd0, v);
      if (!v[0]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int a0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      hread(2'(a), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    chk(phy_req == 0, "R1 req reset", phy_req, 0);

    // R2 R12 field store without execute; R3 extension field
    a0 = acks;
    hwrite(2'd0, cmd_word(13'h123, 7, 1, 0));
    hread(2'd0, v);
    chk(v == exp_acc(13'h123, 7, 1, 0, 0), "R2 R12 field readback", v, exp_acc(13'h123, 7, 1, 0, 0));
    chk(phy_req == 0 && acks == a0, "R12 no transaction", phy_req, 0);
    hwrite(2'd0, cmd_word(8191, 31, 0, 0));
    hread(2'd0, v);
    chk(v == exp_acc(8191, 31, 0, 0, 0), "R3 special page ext", v, exp_acc(8191, 31, 0, 0, 0));
    hwrite(2'd0, cmd_word(4095, 0, 0, 0));
    hread(2'd0, v);
    chk(v == exp_acc(4095, 0, 0, 0, 0), "R3 normal page no ext", v, exp_acc(4095, 0, 0, 0, 0));

    // R6 R4 R5 read sweep over every port
    for (int p = 0; p < 64; p++) begin
      int pg, r;
      pg = (p * 67) % 4096; r = p % 32; delay_cfg = p % 4; a0 = acks;
      hwrite(2'd1, {16'(p), 16'h0});
      hwrite(2'd0, cmd_word(pg, r, 0, 1));
      hread(2'd0, v);
      chk(v[0] == 1 && phy_req == 1, "R4 busy after execute", {v[0], phy_req}, 2'b11);
      wait_idle();
      hread(2'd0, v);
      chk(v == exp_acc(pg, r, 0, 0, 0) && phy_req == 0, "R5 completion clears busy", v, exp_acc(pg, r, 0, 0, 0));
      chk(acks == a0 + 1 && cap_port == 6'(p) && cap_page == 13'(pg) && cap_reg == 5'(r) && cap_wr == 0,
          "R6 read request fields", {cap_port, cap_page, cap_reg}, {6'(p), 13'(pg), 5'(r)});
      hread(2'd1, v);
      chk(v == {16'(p), model_rd(6'(p), 5'(r), 13'(pg))}, "R6 read data", v,
          {16'(p), model_rd(6'(p), 5'(r), 13'(pg))});
    end

    // R7 write sweep over every port
    for (int p = 0; p < 64; p++) begin
      logic [31:0] lo_before;
      logic [15:0] wv;
      wv = 16'(p * 257) ^ 16'h5A5A; delay_cfg = (p * 3) % 5;
      hwrite(2'd2, (p < 32) ? (32'd1 << p) : 32'd0);
      hwrite(2'd3, (p >= 32) ? (32'd1 << (p - 32)) : 32'd0);
      hread(2'd1, lo_before);
      hwrite(2'd1, {wv, 16'h0});
      hwrite(2'd0, cmd_word(p * 13, 31 - (p % 32), 1, 1));
      wait_idle();
      chk(cap_port == 6'(p) && cap_wr == 1 && cap_wdata == wv, "R7 write port and data",
          {cap_port, cap_wdata}, {6'(p), wv});
      hread(2'd1, v);
      chk(v == {wv, lo_before[15:0]}, "R7 lower half kept on write", v, {wv, lo_before[15:0]});
    end

    // R8 rejections
    a0 = acks;
    hwrite(2'd1, {16'd64, 16'h0});
    hwrite(2'd0, cmd_word(5, 1, 0, 1));
    hread(2'd0, v);
    chk(v[1:0] == 2'b10 && phy_req == 0, "R8 port 64 refused", v[1:0], 2'b10);
    hwrite(2'd1, {16'd3, 16'h0});
    hwrite(2'd0, cmd_word(4096, 1, 0, 1));
    hread(2'd0, v);
    chk(v[1:0] == 2'b10 && phy_req == 0, "R8 page 4096 refused", v[1:0], 2'b10);
    hwrite(2'd2, 32'h0); hwrite(2'd3, 32'h0);
    hwrite(2'd0, cmd_word(1, 1, 1, 1));
    hread(2'd0, v);
    chk(v[1:0] == 2'b10 && phy_req == 0, "R8 empty mask refused", v[1:0], 2'b10);
    hwrite(2'd2, 32'h1); hwrite(2'd3, 32'h8000_0000);
    hwrite(2'd0, cmd_word(1, 1, 1, 1));
    hread(2'd0, v);
    chk(v[1:0] == 2'b10 && phy_req == 0, "R8 two-bit mask refused", v[1:0], 2'b10);
    repeat (3) @(negedge clk);
    chk(acks == a0, "R8 no PHY traffic", acks, a0);

    // R11 error cleared by next command; special page accepted
    hwrite(2'd0, cmd_word(8191, 2, 0, 1));
    hread(2'd0, v);
    chk(v[1:0] == 2'b01, "R11 error cleared on issue", v[1:0], 2'b01);
    wait_idle();
    chk(cap_page == 13'h1FFF && cap_port == 3, "R8 special page accepted", cap_page, 13'h1FFF);

    // R9 PHY error response, read and write; then cleared
    err_cfg = 1'b1;
    hwrite(2'd0, cmd_word(9, 4, 0, 1));
    wait_idle();
    hread(2'd0, v);
    chk(v[1:0] == 2'b10, "R9 read error flagged", v[1:0], 2'b10);
    hwrite(2'd2, 32'h10); hwrite(2'd3, 32'h0);
    hwrite(2'd0, cmd_word(9, 4, 1, 1));
    wait_idle();
    hread(2'd0, v);
    chk(v[1:0] == 2'b10, "R9 write error flagged", v[1:0], 2'b10);
    err_cfg = 1'b0;
    hwrite(2'd0, cmd_word(9, 4, 1, 1));
    wait_idle();
    hread(2'd0, v);
    chk(v[1:0] == 2'b00, "R9 R11 clean completion", v[1:0], 2'b00);

    // R10 R13 hand-driven acknowledge
    auto_en = 1'b0; a0 = acks;
    hwrite(2'd1, {16'd5, 16'h0});
    hwrite(2'd0, cmd_word(13'h22, 3, 0, 1));
    repeat (2) @(negedge clk);
    chk(phy_req == 1 && phy_page == 13'h22, "R4 request held", phy_page, 13'h22);
    hwrite(2'd0, cmd_word(13'h33, 9, 1, 1));
    hread(2'd0, v);
    chk(v == exp_acc(13'h22, 3, 0, 0, 1) && phy_page == 13'h22 && phy_wr == 0,
        "R10 command ignored while busy", v, exp_acc(13'h22, 3, 0, 0, 1));
    ack_man = 1'b1; host_we = 1'b1; host_addr = 2'd1; host_wdata = {16'hBEEF, 16'h0};
    @(posedge clk); @(negedge clk);
    ack_man = 1'b0; host_we = 1'b0;
    hread(2'd1, v);
    chk(v == {16'hBEEF, model_rd(6'd5, 5'd3, 13'h22)}, "R13 same-cycle data write",
        v, {16'hBEEF, model_rd(6'd5, 5'd3, 13'h22)});
    hread(2'd0, v);
    chk(v[0] == 0 && phy_req == 0, "R5 manual completion", v[0], 0);
    hwrite(2'd1, {16'd6, 16'h0});
    hwrite(2'd0, cmd_word(13'h44, 8, 0, 1));
    @(negedge clk);
    ack_man = 1'b1; host_we = 1'b1; host_addr = 2'd0; host_wdata = cmd_word(13'h55, 1, 0, 1);
    @(posedge clk); @(negedge clk);
    ack_man = 1'b0; host_we = 1'b0;
    repeat (2) @(negedge clk);
    hread(2'd0, v);
    chk(v == exp_acc(13'h44, 8, 0, 0, 0) && phy_req == 0, "R10 execute at ack ignored",
        v, exp_acc(13'h44, 8, 0, 0, 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule